// File: doc/BRIEF.md
# Pointer Register Address Generator

This block forms the address phase of indirect data-space accesses. Three 16-bit pointers (called X, Y and Z) come in from the general register file, where each one is a pair of 8-bit registers. X is R27:R26, Y is R29:R28 and Z is R31:R30, with the low byte in the even register. When the access strobe is raised, the block takes a pointer select, an addressing mode and a 6-bit unsigned displacement. One clock later it presents the effective data address and a decode of the region that address falls in. For post-increment and pre-decrement it also presents the updated pointer value, with a write-back enable and the pointer it belongs to, so the register file can store the new value.

The register file and the I/O registers sit at the bottom of the same linear data space. The register file takes the first 32 bytes, the 64 I/O registers take the next 64, and SRAM takes everything above. A direct I/O port form turns a port number into its data-space address. Each indirect load or store uses two clock cycles, so the block accepts no new request in the cycle right after one it has accepted. The Z pointer is also registered onto a separate output that serves program-memory table reads and indirect jump or call targets.

Top module: `ptr_agen`

## Requirements
- R1: After synchronous reset, every output is zero: acc_valid, eff_addr, region, wb_en, wb_sel, wb_value and z_addr.
- R2: A request is accepted when strobe is 1, ptr_sel is not 3 and acc_valid is 0. The results appear at the next clock edge with acc_valid = 1 for exactly one cycle. Pointer select codes are X = 0, Y = 1 and Z = 2. Mode codes are plain = 0, post-increment = 1, pre-decrement = 2, displacement = 3 and I/O port = 4; codes 5 to 7 act as plain. In plain mode eff_addr equals the selected pointer and wb_en is 0.
- R3: In post-increment mode eff_addr is the selected pointer and wb_value is the pointer plus 1, modulo 2^16. wb_en is 1 and wb_sel carries the select code.
- R4: In pre-decrement mode eff_addr and wb_value are both the selected pointer minus 1, modulo 2^16 (so 0x0000 becomes 0xFFFF). wb_en is 1 and wb_sel carries the select code.
- R5: In displacement mode with Y or Z, eff_addr is the pointer plus the unsigned displacement (0 to 63), modulo 2^16, and wb_en is 0.
- R6: Displacement mode with X ignores the displacement: eff_addr equals X and wb_en is 0.
- R7: In I/O port mode the displacement is the port number P, eff_addr is P + 0x20, and the pointers have no effect. wb_en is 0.
- R8: region is 0 (register file) for eff_addr 0x00 to 0x1F, 1 (I/O) for 0x20 to 0x5F, and 2 (SRAM) for 0x60 and above.
- R9: A strobe in a cycle where acc_valid is 1 is ignored. acc_valid is 0 at the following edge and wb_en stays 0.
- R10: A strobe with ptr_sel = 3 is ignored. acc_valid and wb_en are 0 at the following edge.
- R11: z_addr equals the value z_ptr had at the previous clock edge, whatever strobe does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Load/store address request |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| mode | input | 3 | Addressing mode code |
| disp | input | 6 | Displacement q or I/O port number |
| x_ptr | input | 16 | X pointer from the register file |
| y_ptr | input | 16 | Y pointer from the register file |
| z_ptr | input | 16 | Z pointer from the register file |
| acc_valid | output | 1 | Address phase result valid for one cycle |
| eff_addr | output | 16 | Effective data-space address |
| region | output | 2 | 0 register file, 1 I/O, 2 SRAM |
| wb_en | output | 1 | Write back the updated pointer |
| wb_sel | output | 2 | Pointer the write-back belongs to |
| wb_value | output | 16 | Updated pointer value |
| z_addr | output | 16 | Registered Z for table reads and indirect jump targets |

## Verification
Any error in the mux, the arithmetic or the decode shows up on eff_addr, region or wb_value in the first valid cycle after the request. No state carries over from one request to the next. The only internal state is the busy condition, which is the valid flag itself. A stuck or missing busy condition shows one cycle later as a second valid pulse after a back-to-back strobe, or as a valid pulse that never comes. The corner cases are wrap-around at 0x0000 and 0xFFFF and the region boundaries at 0x1F/0x20 and 0x5F/0x60. These are driven directly, so an off-by-one in any comparison or a missing modulo shows in the same cycle.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  localparam logic [1:0] SEL_X    = 2'd0;
  localparam logic [1:0] SEL_Y    = 2'd1;
  localparam logic [1:0] SEL_Z    = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  localparam logic [2:0] MODE_PLAIN   = 3'd0;
  localparam logic [2:0] MODE_POSTINC = 3'd1;
  localparam logic [2:0] MODE_PREDEC  = 3'd2;
  localparam logic [2:0] MODE_DISP    = 3'd3;
  localparam logic [2:0] MODE_IOPORT  = 3'd4;

  localparam logic [1:0] REG_RF   = 2'd0;
  localparam logic [1:0] REG_IO   = 2'd1;
  localparam logic [1:0] REG_SRAM = 2'd2;
endpackage

// File: rtl/ptr_mux.sv
module ptr_mux
  import ptr_agen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] x_in,
  input  logic [AW-1:0] y_in,
  input  logic [AW-1:0] z_in,
  output logic [AW-1:0] ptr,
  output logic          is_x,
  output logic          sel_ok
);
  always_comb begin
    ptr    = x_in;
    is_x   = 1'b0;
    sel_ok = 1'b1;
    unique case (sel)
      SEL_X: begin ptr = x_in; is_x = 1'b1; end
      SEL_Y: ptr = y_in;
      SEL_Z: ptr = z_in;
      default: sel_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptr_arith.sv
module ptr_arith
  import ptr_agen_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 6,
  parameter int IO_BASE = 32
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] ptr,
  input  logic          is_x,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] ea,
  output logic          wb_need,
  output logic [AW-1:0] wb_val
);
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] BASE = AW'(IO_BASE);

  logic [AW-1:0] disp_ext;
  assign disp_ext = {{(AW-DW){1'b0}}, disp};

  always_comb begin
    ea      = ptr;
    wb_need = 1'b0;
    wb_val  = ptr;
    case (mode)
      MODE_POSTINC: begin
        wb_need = 1'b1;
        wb_val  = ptr + ONE;
      end
      MODE_PREDEC: begin
        wb_need = 1'b1;
        ea      = ptr - ONE;
        wb_val  = ptr - ONE;
      end
      MODE_DISP: begin
        if (!is_x) ea = ptr + disp_ext;
      end
      MODE_IOPORT: ea = disp_ext + BASE;
      default: ;
    endcase
  end
endmodule

// File: rtl/region_dec.sv
module region_dec
  import ptr_agen_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RF_SIZE = 32,
  parameter int IO_SIZE = 64
) (
  input  logic [AW-1:0] addr,
  output logic [1:0]    region
);
  localparam logic [AW-1:0] RF_END = AW'(RF_SIZE);
  localparam logic [AW-1:0] IO_END = AW'(RF_SIZE + IO_SIZE);

  always_comb begin
    if (addr < RF_END)      region = REG_RF;
    else if (addr < IO_END) region = REG_IO;
    else                    region = REG_SRAM;
  end
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
  import ptr_agen_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 6,
  parameter int RF_SIZE = 32,
  parameter int IO_SIZE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [1:0]        ptr_sel,
  input  logic [2:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] x_ptr,
  input  logic [ADDR_W-1:0] y_ptr,
  input  logic [ADDR_W-1:0] z_ptr,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [1:0]        region,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_value,
  output logic [ADDR_W-1:0] z_addr
);
  localparam int IO_BASE = RF_SIZE;

  logic [ADDR_W-1:0] sel_ptr, ea_c, wbv_c;
  logic              is_x, sel_ok, wb_need;
  logic [1:0]        region_c;
  logic              accept;

  ptr_mux #(.AW(ADDR_W)) u_mux (
    .sel(ptr_sel), .x_in(x_ptr), .y_in(y_ptr), .z_in(z_ptr),
    .ptr(sel_ptr), .is_x(is_x), .sel_ok(sel_ok)
  );

  ptr_arith #(.AW(ADDR_W), .DW(DISP_W), .IO_BASE(IO_BASE)) u_arith (
    .mode(mode), .ptr(sel_ptr), .is_x(is_x), .disp(disp),
    .ea(ea_c), .wb_need(wb_need), .wb_val(wbv_c)
  );

  region_dec #(.AW(ADDR_W), .RF_SIZE(RF_SIZE), .IO_SIZE(IO_SIZE)) u_region (
    .addr(ea_c), .region(region_c)
  );

  // the second cycle of an access doubles as the busy slot
  assign accept = strobe && sel_ok && !acc_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      eff_addr  <= '0;
      region    <= REG_RF;
      wb_en     <= 1'b0;
      wb_sel    <= SEL_X;
      wb_value  <= '0;
      z_addr    <= '0;
    end else begin
      z_addr    <= z_ptr;
      acc_valid <= accept;
      wb_en     <= accept && wb_need;
      if (accept) begin
        eff_addr <= ea_c;
        region   <= region_c;
        wb_sel   <= ptr_sel;
        wb_value <= wbv_c;
      end
    end
  end

  // R9: a valid pulse never lasts two cycles
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> !acc_valid);

  // R2: write-back only during a valid address phase
  p_wb_in_valid_r2: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> acc_valid);

  // R3: post-increment writes back the address plus one
  p_postinc_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(mode) == MODE_POSTINC) |->
      (wb_en && wb_value == eff_addr + ADDR_W'(1)));

  // R4: pre-decrement uses and writes back the same value
  p_predec_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && $past(mode) == MODE_PREDEC) |-> (wb_en && wb_value == eff_addr));

  // R10: an empty select never yields a valid phase
  p_nosel_r10: assert property (@(posedge clk) disable iff (rst)
    (strobe && ptr_sel == SEL_NONE) |=> !acc_valid);

  // R8: address below the register file end decodes as register file
  p_region_rf_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && eff_addr < ADDR_W'(RF_SIZE)) |-> region == REG_RF);

  // R11: Z export lags the input by one edge
  p_zaddr_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> z_addr == $past(z_ptr));
endmodule

// File: tb/test_ptr_agen.sv
`timescale 1ns/1ps
module test_ptr_agen;
  logic        clk = 1'b0;
  logic        rst;
  logic        strobe;
  logic [1:0]  ptr_sel;
  logic [2:0]  mode;
  logic [5:0]  disp;
  logic [15:0] x_ptr, y_ptr, z_ptr;
  logic        acc_valid, wb_en;
  logic [15:0] eff_addr, wb_value, z_addr;
  logic [1:0]  region, wb_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptr_agen i_ptr_agen (
    .clk(clk), .rst(rst), .strobe(strobe), .ptr_sel(ptr_sel), .mode(mode),
    .disp(disp), .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr),
    .acc_valid(acc_valid), .eff_addr(eff_addr), .region(region),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value), .z_addr(z_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_region(input logic [15:0] a);
    if (a < 16'h20) return 2'd0;
    if (a < 16'h60) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [15:0] pick(input logic [1:0] s);
    if (s == 2'd0) return x_ptr;
    if (s == 2'd1) return y_ptr;
    return z_ptr;
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic [1:0] s);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return (s == 2'd0) ? "R6" : "R5";
      3'd4: return "R7";
      default: return "R2";
    endcase
  endfunction

  // one access: drive at negedge, result visible one edge later
  task automatic access(input logic [1:0] s, input logic [2:0] m, input logic [5:0] q);
    logic [15:0] p, ea, wv;
    logic        we;
    string       t;
    ptr_sel = s; mode = m; disp = q; strobe = 1'b1;
    p = pick(s); ea = p; wv = p; we = 1'b0;
    case (m)
      3'd1: begin we = 1'b1; wv = p + 16'd1; end
      3'd2: begin we = 1'b1; ea = p - 16'd1; wv = ea; end
      3'd3: if (s != 2'd0) ea = p + {10'd0, q};
      3'd4: ea = {10'd0, q} + 16'h20;
      default: ;
    endcase
    t = tag_of(m, s);
    @(posedge clk); @(negedge clk);
    strobe = 1'b0;
    if (s == 2'd3) begin
      chk("R10 valid", {31'd0, acc_valid}, 32'd0);
      chk("R10 wb_en", {31'd0, wb_en}, 32'd0);
    end else begin
      chk({t, " valid"}, {31'd0, acc_valid}, 32'd1);
      chk({t, " eff_addr"}, {16'd0, eff_addr}, {16'd0, ea});
      chk({t, " wb_en"}, {31'd0, wb_en}, {31'd0, we});
      if (we) begin
        chk({t, " wb_value"}, {16'd0, wb_value}, {16'd0, wv});
        chk({t, " wb_sel"}, {30'd0, wb_sel}, {30'd0, s});
      end
      chk("R8 region", {30'd0, region}, {30'd0, exp_region(ea)});
    end
    @(posedge clk); @(negedge clk);
    if (s != 2'd3) chk("R2 single pulse", {31'd0, acc_valid}, 32'd0);
  endtask

  function automatic logic [15:0] rnd_ptr();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h001F;
      3: return 16'h005F;
      4: return 16'h0060;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd4242);
    rst = 1'b1; strobe = 1'b0; ptr_sel = 0; mode = 0; disp = 0;
    x_ptr = 16'h1234; y_ptr = 16'h5678; z_ptr = 16'h9ABC;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid", {31'd0, acc_valid}, 32'd0);
    chk("R1 eff_addr", {16'd0, eff_addr}, 32'd0);
    chk("R1 region", {30'd0, region}, 32'd0);
    chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
    chk("R1 wb_sel", {30'd0, wb_sel}, 32'd0);
    chk("R1 wb_value", {16'd0, wb_value}, 32'd0);
    chk("R1 z_addr", {16'd0, z_addr}, 32'd0);
    rst = 1'b0;

    // directed corners
    x_ptr = 16'h0000; access(2'd0, 3'd2, 6'd0);       // R4 wrap to FFFF
    y_ptr = 16'hFFFF; access(2'd1, 3'd1, 6'd0);       // R3 wrap to 0000
    z_ptr = 16'hFFC1; access(2'd2, 3'd3, 6'd63);      // R5 wrap
    x_ptr = 16'h0100; access(2'd0, 3'd3, 6'd40);      // R6 q ignored
    access(2'd1, 3'd4, 6'd0);                          // R7 -> 0x20
    access(2'd2, 3'd4, 6'd63);                         // R7 -> 0x5F
    y_ptr = 16'h001F; access(2'd1, 3'd0, 6'd5);       // R8 boundary
    y_ptr = 16'h0020; access(2'd1, 3'd7, 6'd5);       // R8 boundary, mode 7 plain
    z_ptr = 16'h0060; access(2'd2, 3'd2, 6'd0);       // R8 0x5F
    z_ptr = 16'h0060; access(2'd2, 3'd0, 6'd0);       // R8 0x60
    access(2'd3, 3'd1, 6'd0);                          // R10

    // R9: back-to-back strobe, second one ignored
    x_ptr = 16'h0400;
    ptr_sel = 2'd0; mode = 3'd1; disp = 0; strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 first valid", {31'd0, acc_valid}, 32'd1);
    ptr_sel = 2'd1; mode = 3'd2;
    @(posedge clk); @(negedge clk);
    strobe = 1'b0;
    chk("R9 second ignored", {31'd0, acc_valid}, 32'd0);
    chk("R9 wb_en", {31'd0, wb_en}, 32'd0);

    // R11: z export tracks one edge late
    z_ptr = 16'hBEEF;
    @(posedge clk); @(negedge clk);
    chk("R11 z_addr", {16'd0, z_addr}, 32'h0000BEEF);
    z_ptr = 16'h0042;
    chk("R11 z_addr hold", {16'd0, z_addr}, 32'h0000BEEF);
    @(posedge clk); @(negedge clk);
    chk("R11 z_addr next", {16'd0, z_addr}, 32'h00000042);

    // random mix
    for (int i = 0; i < 400; i++) begin
      x_ptr = rnd_ptr(); y_ptr = rnd_ptr(); z_ptr = rnd_ptr();
      access(2'($urandom % 4), 3'($urandom % 8), 6'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule